// File: doc/BRIEF.md
# Alternating Run-Length Encoder

This block turns a serial test-pattern bitstream into a compact run-length code. It measures every run of identical input bits. Since neighbouring runs always have opposite values, only their lengths need coding. One header bit at the start of each pattern records the value of the first run. Each run length then becomes a variable-length codeword with three fields: a prefix of ones that picks a group of four lengths, a string of zeros that gives the offset inside that group, and a fixed two-bit terminator `01`.

A pattern is closed by marking its last input bit. The run still open at that point is flushed as a final codeword. The pattern's code is then filled with zero bits up to a whole number of 16-bit segments, so that a later dictionary stage can take it as pairs of 8-bit halves. A separate pin marks the end of each 8-bit half.

Both data sides use valid/ready handshakes. A transfer happens on a rising clock edge when valid and ready are both high. The input side accepts a bit only when no coded bits are waiting to be sent. Holding a bit that extends the current run costs nothing. A bit that closes a run, or ends a pattern, stalls the input until the resulting codeword and any padding have been sent. The output side holds its bit and flags steady while `code_ready` is low. The source must keep `pat_valid`, `pat_bit` and `pat_end` steady until the bit is accepted.

Top module: `arl_encoder`

## Requirements
- R1: The first code bit of each pattern is a header bit equal to the value of that pattern's first input bit. It is on `code_bit` with `code_valid` high in the cycle after that input bit is accepted.
- R2: A run of length L from 1 to 3 is coded as L−1 zeros followed by `01`, sent left to right: 1→`01`, 2→`001`, 3→`0001`.
- R3: A run of length L from 4 to 15 is coded as k ones with k = floor(L/4), then L−4k zeros, then `01`. Examples: 4→`101`, 5→`1001`, 8→`1101`, 12→`11101`, 15→`11100001`.
- R4: A run ends when an accepted bit differs from the bit before it. Its codeword follows every earlier code bit of the pattern, and counting restarts at 1 with the new bit.
- R5: When a bit marked with `pat_end` is accepted, the run that contains it is coded as the final codeword of the pattern. This includes a run of length 1 started by that bit.
- R6: After its final codeword, each pattern's code is filled with zero bits up to the next multiple of 16 bits. No fill is added when the code already ends on a boundary. `code_last` is high only on the final bit, and the next pattern starts a new segment.
- R7: `code_half` is high on code bits 7 and 15 of every 16-bit segment, counted from 0 at the first bit of the pattern.
- R8: A run longer than 15 is clipped to length 15 and coded as `11100001`. `clip_err` goes high in the cycle after the 16th identical bit is accepted. It stays high until the first bit of the next pattern is accepted, which clears it.
- R9: While `code_valid` is high and `code_ready` is low, `code_valid`, `code_bit`, `code_last` and `code_half` hold steady. `pat_ready` is low exactly while coded or fill bits are waiting, and high otherwise.
- R10: After reset, `pat_ready` is 1, `code_valid` is 0 and `clip_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_valid | input | 1 | Input bit is valid |
| pat_ready | output | 1 | Encoder can accept an input bit |
| pat_bit | input | 1 | Serial test-pattern bit |
| pat_end | input | 1 | Marks the last bit of a pattern |
| code_valid | output | 1 | Output code bit is valid |
| code_ready | input | 1 | Downstream accepts the code bit |
| code_bit | output | 1 | Serial code bit, sent in codeword order |
| code_last | output | 1 | Final bit of the pattern's padded code |
| code_half | output | 1 | Last bit of an 8-bit half segment |
| clip_err | output | 1 | A run of this pattern exceeded 15 and was clipped |

## Verification
Assertions check four things on every cycle:
- the run counter never reads zero while a run is open;
- a change of bit value restarts the count;
- the clip flag stays set until a new pattern starts;
- a header or codeword that is loaded shows up as valid output, with the header bit equal to the input bit, and the output holds steady under back-pressure and goes idle after the final bit.

Other behaviours can only be shown by the bench's scenarios, which compare every clock against a behavioural model. These are the exact bit sequence of each codeword length, the amount of zero fill, the positions of the half and last markers, the value that replaces a clipped run, and the timing of the flush at end of pattern.

// File: rtl/arl_pkg.sv
package arl_pkg;

  // Default geometry: runs grouped in fours, four groups, 16-bit segments
  localparam int unsigned ARL_GROUP   = 4;
  localparam int unsigned ARL_NGROUPS = 4;
  localparam int unsigned ARL_SEG     = 16;

  // Longest codeword: all group ones, the most zeros, two terminator bits
  function automatic int unsigned arl_cw_bits(int unsigned grp, int unsigned ngr);
    return (ngr - 1) + (grp - 1) + 2;
  endfunction

  // Width of a run-length count (holds 0 .. grp*ngr-1)
  function automatic int unsigned arl_len_bits(int unsigned grp, int unsigned ngr);
    return $clog2(grp * ngr);
  endfunction

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_DATA = 2'd1,
    SER_FILL = 2'd2
  } ser_mode_e;

endpackage

// File: rtl/arl_codeword.sv
module arl_codeword #(
  parameter int unsigned GROUP   = arl_pkg::ARL_GROUP,
  parameter int unsigned NGROUPS = arl_pkg::ARL_NGROUPS,
  localparam int unsigned LEN_W  = arl_pkg::arl_len_bits(GROUP, NGROUPS),
  localparam int unsigned CW_W   = arl_pkg::arl_cw_bits(GROUP, NGROUPS),
  localparam int unsigned CWN_W  = $clog2(CW_W + 1)
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [CW_W-1:0]  code_o,   // left aligned, first bit at MSB
  output logic [CWN_W-1:0] nbits_o
);

  localparam int unsigned E_W = LEN_W + 1;

  logic [LEN_W-1:0] grp_k;
  logic [LEN_W-1:0] zeros_n;
  logic [E_W-1:0]   ones_end;
  logic [E_W-1:0]   zeros_end;

  assign grp_k   = len_i / LEN_W'(GROUP);
  assign zeros_n = (grp_k == '0) ? (len_i - LEN_W'(1))
                                 : (len_i - LEN_W'(int'(grp_k) * int'(GROUP)));

  assign ones_end  = {1'b0, grp_k};
  assign zeros_end = ones_end + {1'b0, zeros_n};

  // Position p (0 = first sent): ones, then zeros, then terminator 0,1
  for (genvar p = 0; p < CW_W; p++) begin : g_bit
    assign code_o[CW_W-1-p] = (E_W'(p) < ones_end) ||
                              (E_W'(p) == zeros_end + E_W'(1));
  end

  assign nbits_o = CWN_W'(zeros_end + E_W'(2));

endmodule

// File: rtl/arl_run_tracker.sv
module arl_run_tracker #(
  parameter int unsigned GROUP   = arl_pkg::ARL_GROUP,
  parameter int unsigned NGROUPS = arl_pkg::ARL_NGROUPS,
  localparam int unsigned LEN_W  = arl_pkg::arl_len_bits(GROUP, NGROUPS),
  localparam int unsigned MAX_RUN = GROUP * NGROUPS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             bit_i,
  input  logic             last_i,
  output logic             hdr_v_o,
  output logic             close_v_o,
  output logic [LEN_W-1:0] close_len_o,
  output logic             flush_v_o,
  output logic [LEN_W-1:0] flush_len_o,
  output logic             clip_o
);

  logic             active_q;
  logic             pol_q;
  logic [LEN_W-1:0] cnt_q;
  logic             clip_q;

  logic             same;
  logic             at_cap;
  logic [LEN_W-1:0] cnt_nx;

  assign same   = active_q && (bit_i == pol_q);
  assign at_cap = (cnt_q == LEN_W'(MAX_RUN));
  assign cnt_nx = !same ? LEN_W'(1) : (at_cap ? cnt_q : cnt_q + LEN_W'(1));

  assign hdr_v_o     = take_i && !active_q;
  assign close_v_o   = take_i && active_q && !same;
  assign close_len_o = cnt_q;
  assign flush_v_o   = take_i && last_i;
  assign flush_len_o = cnt_nx;
  assign clip_o      = clip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pol_q    <= 1'b0;
      cnt_q    <= '0;
      clip_q   <= 1'b0;
    end else if (take_i) begin
      active_q <= !last_i;
      pol_q    <= bit_i;
      cnt_q    <= cnt_nx;
      if (!active_q)
        clip_q <= 1'b0;
      else if (same && at_cap)
        clip_q <= 1'b1;
    end
  end

  // R4
  run_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> cnt_q != '0);

  // R4
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && active_q && (bit_i != pol_q) && !last_i) |=> cnt_q == LEN_W'(1));

  // R8
  clip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clip_q && !(take_i && !active_q)) |=> clip_q);

endmodule

// File: rtl/arl_serializer.sv
module arl_serializer #(
  parameter int unsigned CW_W  = 8,
  parameter int unsigned SEG_W = arl_pkg::ARL_SEG,
  localparam int unsigned CWN_W  = $clog2(CW_W + 1),
  localparam int unsigned BUF_W  = 1 + 2 * CW_W,
  localparam int unsigned BUFN_W = $clog2(BUF_W + 1),
  localparam int unsigned PAD_W  = BUF_W - CW_W,
  localparam int unsigned SEG_CW = $clog2(SEG_W),
  localparam int unsigned HALF_B = $clog2(SEG_W / 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_v_i,
  input  logic             hdr_bit_i,
  input  logic             close_v_i,
  input  logic [CW_W-1:0]  close_code_i,
  input  logic [CWN_W-1:0] close_n_i,
  input  logic             flush_v_i,
  input  logic [CW_W-1:0]  flush_code_i,
  input  logic [CWN_W-1:0] flush_n_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             out_bit_o,
  output logic             out_last_o,
  output logic             out_half_o
);

  import arl_pkg::*;

  logic [BUF_W-1:0]  buf_q;
  logic [BUFN_W-1:0] cnt_q;
  logic [SEG_CW-1:0] seg_q;
  logic              end_q;

  logic [BUFN_W-1:0] hdr_n;
  logic [BUFN_W-1:0] close_n_eff;
  logic [BUFN_W-1:0] flush_n_eff;
  logic [BUF_W-1:0]  load_vec;
  logic [BUFN_W-1:0] load_n;
  logic              load;
  logic              fire;
  logic              seg_wrap;
  ser_mode_e         mode;

  // Pack header, closing codeword and final codeword back to back
  assign hdr_n       = hdr_v_i ? BUFN_W'(1) : '0;
  assign close_n_eff = close_v_i ? BUFN_W'(close_n_i) : '0;
  assign flush_n_eff = flush_v_i ? BUFN_W'(flush_n_i) : '0;

  assign load_vec =
      (hdr_v_i   ? {hdr_bit_i, {(BUF_W-1){1'b0}}} : '0)
    | (close_v_i ? ({close_code_i, {PAD_W{1'b0}}} >> hdr_n) : '0)
    | (flush_v_i ? ({flush_code_i, {PAD_W{1'b0}}} >> (hdr_n + close_n_eff)) : '0);

  assign load_n = hdr_n + close_n_eff + flush_n_eff;
  assign load   = hdr_v_i || close_v_i || flush_v_i;

  always_comb begin
    if (cnt_q != '0)  mode = SER_DATA;
    else if (end_q)   mode = SER_FILL;
    else              mode = SER_IDLE;
  end

  assign seg_wrap    = (seg_q == SEG_CW'(SEG_W - 1));
  assign in_ready_o  = (mode == SER_IDLE);
  assign out_valid_o = (mode != SER_IDLE);
  assign out_bit_o   = (mode == SER_DATA) ? buf_q[BUF_W-1] : 1'b0;
  assign out_last_o  = end_q && seg_wrap && (cnt_q <= BUFN_W'(1));
  assign out_half_o  = &seg_q[HALF_B-1:0];
  assign fire        = out_valid_o && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
      seg_q <= '0;
      end_q <= 1'b0;
    end else if (load) begin
      buf_q <= load_vec;
      cnt_q <= load_n;
      if (flush_v_i) end_q <= 1'b1;
    end else if (fire) begin
      buf_q <= buf_q << 1;
      if (cnt_q != '0) cnt_q <= cnt_q - BUFN_W'(1);
      seg_q <= seg_wrap ? '0 : seg_q + SEG_CW'(1);
      if (out_last_o) end_q <= 1'b0;
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_bit_o) && $stable(out_last_o) && $stable(out_half_o)));

  // R6
  last_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last_o) |=> (!out_valid_o && in_ready_o));

endmodule

// File: rtl/arl_encoder.sv
module arl_encoder #(
  parameter int unsigned GROUP   = arl_pkg::ARL_GROUP,
  parameter int unsigned NGROUPS = arl_pkg::ARL_NGROUPS,
  parameter int unsigned SEG_W   = arl_pkg::ARL_SEG
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pat_valid,
  output logic pat_ready,
  input  logic pat_bit,
  input  logic pat_end,
  output logic code_valid,
  input  logic code_ready,
  output logic code_bit,
  output logic code_last,
  output logic code_half,
  output logic clip_err
);

  localparam int unsigned LEN_W  = arl_pkg::arl_len_bits(GROUP, NGROUPS);
  localparam int unsigned CW_W   = arl_pkg::arl_cw_bits(GROUP, NGROUPS);
  localparam int unsigned CWN_W  = $clog2(CW_W + 1);
  localparam int unsigned NSLOT  = 2;   // slot 0: closing run, slot 1: final run

  logic             take;
  logic             hdr_v;
  logic             close_v;
  logic             flush_v;
  logic [LEN_W-1:0] close_len;
  logic [LEN_W-1:0] flush_len;

  logic [LEN_W-1:0] cw_len  [NSLOT];
  logic [CW_W-1:0]  cw_code [NSLOT];
  logic [CWN_W-1:0] cw_n    [NSLOT];

  assign take = pat_valid && pat_ready;

  arl_run_tracker #(.GROUP(GROUP), .NGROUPS(NGROUPS)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .bit_i       (pat_bit),
    .last_i      (pat_end),
    .hdr_v_o     (hdr_v),
    .close_v_o   (close_v),
    .close_len_o (close_len),
    .flush_v_o   (flush_v),
    .flush_len_o (flush_len),
    .clip_o      (clip_err)
  );

  assign cw_len[0] = close_len;
  assign cw_len[1] = flush_len;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    arl_codeword #(.GROUP(GROUP), .NGROUPS(NGROUPS)) u_cw (
      .len_i   (cw_len[s]),
      .code_o  (cw_code[s]),
      .nbits_o (cw_n[s])
    );
  end

  arl_serializer #(.CW_W(CW_W), .SEG_W(SEG_W)) u_ser (
    .clk          (clk),
    .rst_n        (rst_n),
    .hdr_v_i      (hdr_v),
    .hdr_bit_i    (pat_bit),
    .close_v_i    (close_v),
    .close_code_i (cw_code[0]),
    .close_n_i    (cw_n[0]),
    .flush_v_i    (flush_v),
    .flush_code_i (cw_code[1]),
    .flush_n_i    (cw_n[1]),
    .in_ready_o   (pat_ready),
    .out_valid_o  (code_valid),
    .out_ready_i  (code_ready),
    .out_bit_o    (code_bit),
    .out_last_o   (code_last),
    .out_half_o   (code_half)
  );

  // R9
  load_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_v || close_v || flush_v) |=> (code_valid && !pat_ready));

  // R1
  hdr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_v |=> (code_valid && code_bit == $past(pat_bit)));

endmodule

// File: tb/arl_encoder_tb.sv
`timescale 1ns/1ps
module arl_encoder_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pat_valid = 1'b0, pat_bit = 1'b0, pat_end = 1'b0;
  logic pat_ready, code_valid, code_bit, code_last, code_half, clip_err;
  logic code_ready = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  arl_encoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_bit(pat_bit), .pat_end(pat_end),
    .code_valid(code_valid), .code_ready(code_ready), .code_bit(code_bit),
    .code_last(code_last), .code_half(code_half), .clip_err(clip_err)
  );

  int checks = 0;
  int errors = 0;

  // stimulus
  bit stim_bit [$];
  bit stim_last [$];
  int stim_idx = 0;

  // reference model
  bit    exp_bit  [$];
  bit    exp_last [$];
  bit    exp_half [$];
  string exp_tag  [$];
  int    pat_pos = 0;
  bit    m_active = 0, m_pol = 0, m_clip = 0, m_runclip = 0;
  int    m_cnt = 0;
  int    ready_pct = 100;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push_bit(bit b, string tag);
    exp_bit.push_back(b);
    exp_half.push_back((pat_pos % 8) == 7);
    exp_last.push_back(1'b0);
    exp_tag.push_back(tag);
    pat_pos++;
  endtask

  task automatic push_cw(int len, string tag);
    int k = len / 4;
    int z = (k == 0) ? len - 1 : len - 4 * k;
    for (int i = 0; i < k; i++) push_bit(1'b1, tag);
    for (int i = 0; i < z; i++) push_bit(1'b0, tag);
    push_bit(1'b0, tag);
    push_bit(1'b1, tag);
  endtask

  task automatic model_take(bit b, bit last);
    if (!m_active) begin
      push_bit(b, "R1");
      m_active = 1; m_pol = b; m_cnt = 1; m_clip = 0; m_runclip = 0;
    end else if (b == m_pol) begin
      if (m_cnt == 15) begin m_clip = 1; m_runclip = 1; end
      else m_cnt++;
    end else begin
      push_cw(m_cnt, m_runclip ? "R8" : (m_cnt < 4 ? "R2/R4" : "R3/R4"));
      m_pol = b; m_cnt = 1; m_runclip = 0;
    end
    if (last) begin
      push_cw(m_cnt, m_runclip ? "R8" : "R5");
      while (pat_pos % 16 != 0) push_bit(1'b0, "R6");
      exp_last[exp_last.size() - 1] = 1'b1;
      pat_pos = 0;
      m_active = 0;
    end
  endtask

  task automatic add_run(bit pol, int len);
    for (int i = 0; i < len; i++) begin
      stim_bit.push_back(pol);
      stim_last.push_back(1'b0);
    end
  endtask

  task automatic end_pattern();
    stim_last[stim_last.size() - 1] = 1'b1;
  endtask

  // drive one stimulus block until the model and the stimulus are drained
  task automatic run_block(int pct, output bit hung);
    bit pend = 0;
    int cyc = 0;
    hung = 0;
    ready_pct = pct;
    while (stim_idx < stim_bit.size() || exp_bit.size() != 0 || pend) begin
      @(negedge clk);
      cyc++;
      if (cyc > 40000) begin hung = 1; return; end
      // compare against the model
      check(pat_ready == (exp_bit.size() == 0), "R9", "pat_ready", pat_ready, exp_bit.size() == 0);
      check(code_valid == (exp_bit.size() != 0), "R9", "code_valid", code_valid, exp_bit.size() != 0);
      if (code_valid && exp_bit.size() != 0) begin
        check(code_bit == exp_bit[0], exp_tag[0], "code_bit", code_bit, exp_bit[0]);
        check(code_last == exp_last[0], "R6", "code_last", code_last, exp_last[0]);
        check(code_half == exp_half[0], "R7", "code_half", code_half, exp_half[0]);
      end
      check(clip_err == m_clip, "R8", "clip_err", clip_err, m_clip);
      // drive
      code_ready = (($urandom % 100) < ready_pct);
      if (!pend) begin
        if (stim_idx < stim_bit.size() && ($urandom % 5 != 0)) begin
          pat_valid = 1'b1;
          pat_bit   = stim_bit[stim_idx];
          pat_end   = stim_last[stim_idx];
        end else begin
          pat_valid = 1'b0;
          pat_end   = 1'b0;
        end
      end
      // predict the coming edge
      if (code_valid && code_ready && exp_bit.size() != 0) begin
        void'(exp_bit.pop_front()); void'(exp_last.pop_front());
        void'(exp_half.pop_front()); void'(exp_tag.pop_front());
      end
      if (pat_valid && pat_ready) begin
        model_take(pat_bit, pat_end);
        stim_idx++;
        pend = 0;
      end else begin
        pend = pat_valid;
      end
    end
    @(negedge clk);
    pat_valid = 1'b0;
    pat_end = 1'b0;
  endtask

  initial begin
    bit hung = 0;
    int pol;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(pat_ready == 1'b1, "R10", "pat_ready", pat_ready, 1);
    check(code_valid == 1'b0, "R10", "code_valid", code_valid, 0);
    check(clip_err == 1'b0, "R10", "clip_err", clip_err, 0);
    rst_n = 1'b1;

    // lengths 1..15 alternating, final run flushed (R2 R3 R4 R5)
    for (int l = 1; l <= 15; l++) add_run(l % 2, l);
    end_pattern();
    if (!hung) run_block(100, hung);

    // single-bit pattern: header + flush of length 1 + fill (R1 R5 R6)
    add_run(1'b0, 1); end_pattern();
    // code of exactly 16 bits, no fill (R6)
    add_run(1'b0, 15); add_run(1'b1, 3); add_run(1'b0, 2); end_pattern();
    if (!hung) run_block(40, hung);

    // clipped run closed by a change, then a fresh pattern clears the flag (R8)
    add_run(1'b1, 20); add_run(1'b0, 2); end_pattern();
    add_run(1'b0, 3); add_run(1'b1, 1); end_pattern();
    // clipped run flushed at end of pattern (R8 R5)
    add_run(1'b0, 18); end_pattern();
    if (!hung) run_block(70, hung);

    // random patterns under varying back-pressure (R2 R3 R4 R7 R9)
    for (int p = 0; p < 12 && !hung; p++) begin
      pol = $urandom % 2;
      for (int r = 0; r < 3 + ($urandom % 8); r++) begin
        add_run(pol[0], 1 + ($urandom % 17));
        pol = 1 - pol;
      end
      end_pattern();
      run_block((p % 3 == 0) ? 25 : 85, hung);
    end

    if (hung) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule